// File: doc/BRIEF.md
# Eight-Level Programmable Interrupt Controller

This block collects up to eight interrupt request lines, ranks the pending ones with a rotating priority scheme and raises a single interrupt output toward a processor. Software sets it up and steers it through a byte-wide register port with two addresses. The command address (addr = 0) takes initialization starts and operation commands. The data address (addr = 1) takes the remaining initialization words, or the mask once setup is complete.

The processor pulses `inta` to acknowledge. The controller then marks the winning level as in service and returns a vector made from a programmed base and the level number. In-service levels are released by end-of-interrupt commands, either specific or nonspecific and optionally rotating, or automatically at acknowledge time. Software can also poll instead of acknowledging, and it can read back the request, in-service and mask registers.

The trigger mode of each line is fixed per instance by the `LEVEL_MASK` parameter. A set bit makes the line level-sensitive. A clear bit makes it rising-edge-sensitive.

Top module: `pic8_core`

## Requirements
- R1: A command write with bit 4 set starts initialization. From the next cycle the request, in-service and mask registers, the priority offset, automatic end-of-interrupt, rotate-on-automatic-EOI and the status select read as zero, and `int_out` is low. Bit 0 of this write records whether a fourth setup word will follow.
- R2: During setup, the first data write loads the vector base from bits 7:3. The second data write is consumed without effect. A third data write is taken as the mode word only if a fourth word was requested, and its bit 1 enables automatic end-of-interrupt. Without that request, the third data write loads the mask.
- R3: Outside setup, a data write loads the mask, and a data-address read returns the mask.
- R4: An edge line sets its request bit on a low-to-high transition, and the bit stays set after the line falls. A level line's request bit follows the line one cycle later and is not cleared by acknowledge.
- R5: Priority is searched from level `offset` upward, wrapping modulo 8. The first pending level found wins.
- R6: `int_out` is high only when an unmasked request exists whose priority is strictly higher than that of the highest in-service level.
- R7: On `inta` with a request raised, `vector` becomes base·8 + winning level and that level's in-service bit is set. Its request bit is cleared if the line is edge-triggered. With nothing raised, `vector` is base·8 + 7 and no state changes.
- R8: With automatic end-of-interrupt on, acknowledge leaves the in-service register unchanged. If rotation was enabled by command code 4 in bits 7:5 (code 0 disables it), the offset becomes level + 1 at the same time.
- R9: A command write with bits 4 and 3 clear and code 1 in bits 7:5 clears the highest-priority in-service bit. Code 5 does the same and then sets the offset to that level + 1.
- R10: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and sets the offset to that level + 1.
- R11: Code 6 sets the offset to bits 2:0 + 1 without touching the in-service register.
- R12: A command write with bit 4 clear and bit 3 set arms a poll when bit 2 is set. When bit 1 is set, bit 0 selects in-service (1) or request (0) for command-address reads. A read while a poll is armed returns the winning level and clears its request and in-service bits, or returns 7 when nothing is raised. Either way the poll is then disarmed.
- R13: If a new rising edge arrives on an edge line in the same cycle that the line's pending request is acknowledged, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered on the read strobe |
| inta | input | 1 | Interrupt acknowledge pulse |
| vector | output | 8 | Acknowledge vector, registered on `inta` |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The collision of interest is between an acknowledge and a fresh edge on the same line. The acknowledge clears the edge line's request bit, while the incoming transition tries to set it in that same cycle. The bench provokes it by raising a line, letting it fall, and then driving it high again in exactly the cycle that `inta` is pulsed. It then reads the request register back through the command address and expects the bit to still be set. It also confirms that `int_out` stays low only while the matching in-service bit is held.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_BASE = 2'd1,
    INIT_CASC = 2'd2,
    INIT_MODE = 2'd3
  } init_st_t;

  localparam logic [2:0] OP_RAEOI_CLR   = 3'd0;
  localparam logic [2:0] OP_EOI_NS      = 3'd1;
  localparam logic [2:0] OP_EOI_SP      = 3'd3;
  localparam logic [2:0] OP_RAEOI_SET   = 3'd4;
  localparam logic [2:0] OP_EOI_NS_ROT  = 3'd5;
  localparam logic [2:0] OP_SET_PRI     = 3'd6;
  localparam logic [2:0] OP_EOI_SP_ROT  = 3'd7;

endpackage

// File: rtl/pic8_prio.sv
module pic8_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0]         bits,
  input  logic [$clog2(N)-1:0] offset,
  output logic                 found,
  output logic [$clog2(N)-1:0] rank,
  output logic [$clog2(N)-1:0] level
);
  localparam int LW = $clog2(N);

  logic [LW-1:0] idx;

  // Scan from the highest rank down so the lowest rank is written last.
  always_comb begin
    found = 1'b0;
    rank  = '0;
    level = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      idx = LW'(i) + offset;
      if (bits[idx]) begin
        found = 1'b1;
        rank  = LW'(i);
        level = idx;
      end
    end
  end
endmodule

// File: rtl/pic8_reqlatch.sv
module pic8_reqlatch #(
  parameter int          N          = 8,
  parameter logic [N-1:0] LEVEL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_all,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= line_in;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    if (LEVEL_MASK[g]) begin : g_level
      always_ff @(posedge clk) begin
        if (rst || clear_all) irr[g] <= 1'b0;
        else                  irr[g] <= line_in[g];
      end
    end else begin : g_edge
      // A new edge wins over a clear in the same cycle.
      always_ff @(posedge clk) begin
        if (rst || clear_all) irr[g] <= 1'b0;
        else                  irr[g] <= (irr[g] & ~clr[g]) | (line_in[g] & ~prev[g]);
      end
    end
  end
endmodule

// File: rtl/pic8_core.sv
module pic8_core
  import pic8_pkg::*;
#(
  parameter int                 N_LINES    = 8,
  parameter logic [N_LINES-1:0] LEVEL_MASK = 8'h80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic               inta,
  output logic [7:0]         vector,
  output logic               int_out
);
  localparam int DW     = 8;
  localparam int LW     = $clog2(N_LINES);
  localparam int BASE_W = DW - LW;

  logic [N_LINES-1:0] irr, imr, isr, isr_n, irr_clr;
  logic [LW-1:0]      offset, ofs_n;
  logic [BASE_W-1:0]  base;
  init_st_t           init_st;
  logic               need4, aeoi, rot_aeoi, rsel, poll;

  logic               req_found, isr_found;
  logic [LW-1:0]      req_rank, req_level, isr_rank, isr_level;

  logic               cmd_wr, dat_wr, is_init, is_ocw3, is_ocw2;
  logic [2:0]         op;
  logic [LW-1:0]      lvl_arg;
  logic               raise, ack_hit, poll_hit;

  assign cmd_wr  = wr_en & ~addr;
  assign dat_wr  = wr_en & addr;
  assign is_init = cmd_wr & wdata[4];
  assign is_ocw3 = cmd_wr & ~wdata[4] & wdata[3];
  assign is_ocw2 = cmd_wr & ~wdata[4] & ~wdata[3];
  assign op      = wdata[7:5];
  assign lvl_arg = wdata[LW-1:0];

  pic8_reqlatch #(.N(N_LINES), .LEVEL_MASK(LEVEL_MASK)) u_latch (
    .clk(clk), .rst(rst), .clear_all(is_init),
    .line_in(irq_in), .clr(irr_clr), .irr(irr)
  );

  pic8_prio #(.N(N_LINES)) u_req_prio (
    .bits(irr & ~imr), .offset(offset),
    .found(req_found), .rank(req_rank), .level(req_level)
  );

  pic8_prio #(.N(N_LINES)) u_isr_prio (
    .bits(isr), .offset(offset),
    .found(isr_found), .rank(isr_rank), .level(isr_level)
  );

  assign raise    = req_found && (!isr_found || (req_rank < isr_rank));
  assign int_out  = raise;
  assign ack_hit  = inta & raise;
  assign poll_hit = rd_en & poll & raise;
  assign irr_clr  = (ack_hit || poll_hit) ? (N_LINES'(1) << req_level) : '0;

  always_comb begin
    isr_n = isr;
    ofs_n = offset;
    if (ack_hit) begin
      if (aeoi) begin
        if (rot_aeoi) ofs_n = req_level + 1'b1;
      end else begin
        isr_n[req_level] = 1'b1;
      end
    end
    if (poll_hit) isr_n[req_level] = 1'b0;
    if (is_ocw2) begin
      case (op)
        OP_EOI_NS, OP_EOI_NS_ROT: begin
          if (isr_found) begin
            isr_n[isr_level] = 1'b0;
            if (op == OP_EOI_NS_ROT) ofs_n = isr_level + 1'b1;
          end
        end
        OP_EOI_SP, OP_EOI_SP_ROT: begin
          isr_n[lvl_arg] = 1'b0;
          if (op == OP_EOI_SP_ROT) ofs_n = lvl_arg + 1'b1;
        end
        OP_SET_PRI: ofs_n = lvl_arg + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr      <= '0;
      isr      <= '0;
      offset   <= '0;
      base     <= '0;
      init_st  <= INIT_IDLE;
      need4    <= 1'b0;
      aeoi     <= 1'b0;
      rot_aeoi <= 1'b0;
      rsel     <= 1'b0;
      poll     <= 1'b0;
    end else if (is_init) begin
      imr      <= '0;
      isr      <= '0;
      offset   <= '0;
      init_st  <= INIT_BASE;
      need4    <= wdata[0];
      aeoi     <= 1'b0;
      rot_aeoi <= 1'b0;
      rsel     <= 1'b0;
      poll     <= 1'b0;
    end else begin
      isr    <= isr_n;
      offset <= ofs_n;
      if (rd_en && poll) poll <= 1'b0;
      if (dat_wr) begin
        case (init_st)
          INIT_IDLE: imr <= wdata[N_LINES-1:0];
          INIT_BASE: begin
            base    <= wdata[DW-1:LW];
            init_st <= INIT_CASC;
          end
          INIT_CASC: init_st <= need4 ? INIT_MODE : INIT_IDLE;
          INIT_MODE: begin
            aeoi    <= wdata[1];
            init_st <= INIT_IDLE;
          end
          default: init_st <= INIT_IDLE;
        endcase
      end
      if (is_ocw3) begin
        if (wdata[2]) poll <= 1'b1;
        if (wdata[1]) rsel <= wdata[0];
      end
      if (is_ocw2 && (op == OP_RAEOI_CLR || op == OP_RAEOI_SET))
        rot_aeoi <= op[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      vector <= '0;
    end else begin
      if (rd_en) begin
        if (poll)      rdata <= raise ? DW'(req_level) : DW'(N_LINES - 1);
        else if (addr) rdata <= DW'(imr);
        else           rdata <= rsel ? DW'(isr) : DW'(irr);
      end
      if (inta) vector <= {base, (ack_hit ? req_level : {LW{1'b1}})};
    end
  end
endmodule

// File: rtl/pic8_checker.sv
module pic8_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         rd_en,
  input logic         addr,
  input logic [7:0]   wdata,
  input logic         inta,
  input logic         int_out,
  input logic [7:0]   vector,
  input logic [N-1:0] irr,
  input logic [N-1:0] imr,
  input logic [N-1:0] isr,
  input logic [1:0]   init_st,
  input logic         aeoi,
  input logic         poll
);
  localparam int LW = $clog2(N);

  a_r1_init_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=> (irr == '0 && isr == '0 && imr == '0 && !int_out));

  a_r3_mask_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && init_st == 2'd0) |=> (imr == $past(wdata[N-1:0])));

  a_r6_no_request_no_int: assert property (@(posedge clk) disable iff (rst)
    ((irr & ~imr) == '0) |-> !int_out);

  a_r7_ack_marks_service: assert property (@(posedge clk) disable iff (rst)
    (inta && int_out && !aeoi && !wr_en && !rd_en) |=> isr[vector[LW-1:0]]);

  a_r8_aeoi_keeps_service: assert property (@(posedge clk) disable iff (rst)
    (inta && aeoi && !wr_en && !rd_en) |=> (isr == $past(isr)));

  a_r12_poll_single: assert property (@(posedge clk) disable iff (rst)
    (rd_en && poll && !wr_en) |=> !poll);
endmodule

bind pic8_core pic8_checker #(.N(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .inta(inta), .int_out(int_out), .vector(vector),
  .irr(irr), .imr(imr), .isr(isr), .init_st(init_st),
  .aeoi(aeoi), .poll(poll)
);

// File: tb/tb_pic8_core.sv
`timescale 1ns/1ps
module tb_pic8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vector;
  logic       int_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pic8_core #(.N_LINES(8), .LEVEL_MASK(8'h80)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .inta(inta),
    .vector(vector), .int_out(int_out)
  );

  localparam logic [1:0] WR = 2'd0, RD = 2'd1, AK = 2'd2, ID = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic       a;
    logic [7:0] wd;
    logic [7:0] irq;
    logic [7:0] exp;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t TBL [NV] = '{
    '{WR, 1'b0, 8'h11, 8'h00, 8'h00, 4'd1},  // R1 init, mode word wanted
    '{WR, 1'b1, 8'h40, 8'h00, 8'h00, 4'd2},  // R2 base 0x40
    '{WR, 1'b1, 8'h00, 8'h00, 8'h00, 4'd2},
    '{WR, 1'b1, 8'h00, 8'h00, 8'h00, 4'd2},  // mode word, no auto EOI
    '{RD, 1'b1, 8'h00, 8'h00, 8'h00, 4'd3},  // R3 mask reads zero
    '{WR, 1'b1, 8'hF0, 8'h00, 8'h00, 4'd3},
    '{RD, 1'b1, 8'h00, 8'h00, 8'hF0, 4'd3},  // R3
    '{ID, 1'b0, 8'h00, 8'h10, 8'h00, 4'd6},  // R6 masked line 4
    '{WR, 1'b0, 8'h0A, 8'h10, 8'h00, 4'd12},
    '{RD, 1'b0, 8'h00, 8'h10, 8'h10, 4'd12}, // R12 request readback
    '{ID, 1'b0, 8'h00, 8'h14, 8'h01, 4'd6},  // R6 line 2 raises
    '{ID, 1'b0, 8'h00, 8'h00, 8'h01, 4'd4},  // R4 edge kept
    '{AK, 1'b0, 8'h00, 8'h00, 8'h42, 4'd7},  // R7
    '{ID, 1'b0, 8'h00, 8'h00, 8'h00, 4'd6},
    '{WR, 1'b0, 8'h0B, 8'h00, 8'h00, 4'd12},
    '{RD, 1'b0, 8'h00, 8'h00, 8'h04, 4'd7},  // R7 in-service bit 2
    '{ID, 1'b0, 8'h00, 8'h01, 8'h01, 4'd6},  // R6 nesting
    '{AK, 1'b0, 8'h00, 8'h01, 8'h40, 4'd7},
    '{ID, 1'b0, 8'h00, 8'h00, 8'h00, 4'd6},
    '{WR, 1'b0, 8'h20, 8'h00, 8'h00, 4'd9},  // R9 nonspecific EOI
    '{RD, 1'b0, 8'h00, 8'h00, 8'h04, 4'd9},
    '{WR, 1'b0, 8'h62, 8'h00, 8'h00, 4'd10}, // R10 specific EOI level 2
    '{RD, 1'b0, 8'h00, 8'h00, 8'h00, 4'd10},
    '{WR, 1'b0, 8'hC3, 8'h00, 8'h00, 4'd11}, // R11 offset 4
    '{WR, 1'b1, 8'h00, 8'h00, 8'h00, 4'd3},
    '{ID, 1'b0, 8'h00, 8'h02, 8'h01, 4'd5},
    '{AK, 1'b0, 8'h00, 8'h02, 8'h44, 4'd5},  // R5 level 4 beats level 1
    '{ID, 1'b0, 8'h00, 8'h00, 8'h00, 4'd5},
    '{WR, 1'b0, 8'hA0, 8'h00, 8'h00, 4'd9},  // R9 rotating EOI, offset 5
    '{ID, 1'b0, 8'h00, 8'h00, 8'h01, 4'd9},
    '{AK, 1'b0, 8'h00, 8'h00, 8'h41, 4'd9},
    '{WR, 1'b0, 8'hE1, 8'h00, 8'h00, 4'd10}, // R10 rotate on level 1
    '{RD, 1'b0, 8'h00, 8'h00, 8'h00, 4'd10},
    '{ID, 1'b0, 8'h00, 8'h28, 8'h01, 4'd5},
    '{WR, 1'b0, 8'h0C, 8'h28, 8'h00, 4'd12},
    '{RD, 1'b0, 8'h00, 8'h28, 8'h03, 4'd12}, // R12 poll level 3
    '{RD, 1'b0, 8'h00, 8'h28, 8'h00, 4'd12},
    '{WR, 1'b0, 8'h0C, 8'h28, 8'h00, 4'd12},
    '{RD, 1'b0, 8'h00, 8'h28, 8'h05, 4'd12},
    '{WR, 1'b0, 8'h0C, 8'h28, 8'h00, 4'd12},
    '{RD, 1'b0, 8'h00, 8'h28, 8'h07, 4'd12}, // R12 empty poll
    '{ID, 1'b0, 8'h00, 8'h00, 8'h00, 4'd12},
    '{WR, 1'b0, 8'h13, 8'h00, 8'h00, 4'd1},
    '{WR, 1'b1, 8'h80, 8'h00, 8'h00, 4'd2},
    '{WR, 1'b1, 8'h00, 8'h00, 8'h00, 4'd2},
    '{WR, 1'b1, 8'h02, 8'h00, 8'h00, 4'd2},  // R2 auto EOI on
    '{RD, 1'b1, 8'h00, 8'h00, 8'h00, 4'd1},
    '{WR, 1'b0, 8'h80, 8'h00, 8'h00, 4'd8},  // R8 rotate on auto EOI
    '{ID, 1'b0, 8'h00, 8'h01, 8'h01, 4'd8},
    '{AK, 1'b0, 8'h00, 8'h01, 8'h80, 4'd8},
    '{WR, 1'b0, 8'h0B, 8'h01, 8'h00, 4'd8},
    '{RD, 1'b0, 8'h00, 8'h01, 8'h00, 4'd8},  // R8 nothing in service
    '{ID, 1'b0, 8'h00, 8'h00, 8'h00, 4'd8},
    '{ID, 1'b0, 8'h00, 8'h03, 8'h01, 4'd8},
    '{AK, 1'b0, 8'h00, 8'h03, 8'h81, 4'd8},  // R8 offset 1 picks level 1
    '{AK, 1'b0, 8'h00, 8'h03, 8'h80, 4'd8}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int tag,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic a, input logic [7:0] wd,
                      input logic [7:0] irqv, input logic [7:0] expv, input int tag);
    @(negedge clk);
    irq_in = irqv;
    addr   = a;
    wdata  = wd;
    wr_en  = (op == WR);
    rd_en  = (op == RD);
    inta   = (op == AK);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    inta  = 1'b0;
    case (op)
      RD: check(rdata, expv, tag, "rdata");
      AK: check(vector, expv, tag, "vector");
      ID: check({7'b0, int_out}, expv, tag, "int_out");
      default: ;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check({7'b0, int_out}, 8'h00, 1, "reset int_out");
    check(vector, 8'h00, 1, "reset vector");
    step(RD, 1'b1, 8'h00, 8'h00, 8'h00, 1);

    for (int i = 0; i < NV; i++)
      step(TBL[i].op, TBL[i].a, TBL[i].wd, TBL[i].irq, TBL[i].exp, int'(TBL[i].tag));

    // R2 setup without a mode word: third data write is the mask
    step(ID, 1'b0, 8'h00, 8'h00, 8'h00, 2);
    step(WR, 1'b0, 8'h10, 8'h00, 8'h00, 2);
    step(WR, 1'b1, 8'h28, 8'h00, 8'h00, 2);
    step(WR, 1'b1, 8'h00, 8'h00, 8'h00, 2);
    step(WR, 1'b1, 8'h55, 8'h00, 8'h00, 2);
    step(RD, 1'b1, 8'h00, 8'h00, 8'h55, 2);
    step(WR, 1'b1, 8'h00, 8'h00, 8'h00, 3);

    // R4 level line 7
    step(ID, 1'b0, 8'h00, 8'h80, 8'h01, 4);
    step(AK, 1'b0, 8'h00, 8'h80, 8'h2F, 7);
    step(WR, 1'b0, 8'h0A, 8'h80, 8'h00, 4);
    step(RD, 1'b0, 8'h00, 8'h80, 8'h80, 4);
    step(ID, 1'b0, 8'h00, 8'h00, 8'h00, 4);
    step(RD, 1'b0, 8'h00, 8'h00, 8'h00, 4);
    step(WR, 1'b0, 8'h20, 8'h00, 8'h00, 9);

    // R7 spurious acknowledge
    step(AK, 1'b0, 8'h00, 8'h00, 8'h2F, 7);

    // R13 new edge during acknowledge of the same line
    step(ID, 1'b0, 8'h00, 8'h08, 8'h01, 13);
    step(ID, 1'b0, 8'h00, 8'h00, 8'h01, 13);
    step(AK, 1'b0, 8'h00, 8'h08, 8'h2B, 13);
    step(RD, 1'b0, 8'h00, 8'h08, 8'h08, 13);
    step(ID, 1'b0, 8'h00, 8'h08, 8'h00, 6);
    step(WR, 1'b0, 8'h20, 8'h08, 8'h00, 13);
    step(ID, 1'b0, 8'h00, 8'h08, 8'h01, 13);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule